// File: doc/BRIEF.md
# Power-Management Idle Controller

This block keeps the processor's power-management control word and turns a software store into a core halt. Software reaches the word through the special-register port at group 8, number 0. The flat address is the group shifted left by 11 plus the number, which gives 16'h4000. The stored word is decoded into five outputs: a frequency slow-down factor, a doze request, a sleep request, a clock-gating enable and a suspend enable. The circuits that act on these fields sit outside this block.

A store that leaves the doze or sleep request set does three things. It saves the value. It pulses a strobe that tells the pipeline to step its next PC one instruction (4 bytes) past the store. It raises the halt output. Halt drops again one clock after a wake event. Three events wake the core: exception entry, a pending enabled interrupt, and a kick from tick-timer reprogramming. Exception entry also clears both request bits, so the core does not fall straight back into idle when the handler returns.

Top module: `pm_idle_ctrl`

## Requirements
- R1: Only the flat address 16'h4000 (group 8 shifted left by 11, plus number 0) is decoded. A store to any other address changes nothing, and a read at any other address returns zero.
- R2: The stored field layout is as follows. Bits 3:0 hold the slow-down factor. Bit 4 is the doze request, bit 5 the sleep request, bit 6 the clock-gating enable and bit 7 the suspend enable. Each field drives its own output. Store bits 31:8 are discarded.
- R3: A decoded store whose data has bit 4 or bit 5 set, with no exception entry in the same cycle, takes effect one clock later. From that clock `halt_o` is high, and `pc_adv_o` is high for exactly one cycle.
- R4: Exception entry clears bits 4 and 5 of the stored word one clock later and keeps the other bits. If a store arrives in the same cycle, its other bits are kept, its request bits are cleared, and neither halt nor the PC strobe follows.
- R5: A read at the decoded address returns the whole stored word, zero-extended to 32 bits, combinationally in the same cycle.
- R6: While halted, any of `exc_entry_i`, `irq_pending_i` or `timer_kick_i` drops `halt_o` one clock later. Halt then stays low until the next qualifying store.
- R7: A decoded store with bits 4 and 5 both clear updates the word and raises neither `halt_o` nor `pc_adv_o`.
- R8: Reset clears the stored word to zero and holds `halt_o` and `pc_adv_o` low, even when it arrives during a halt.
- R9: While halted with no wake event, `halt_o` stays high and `pc_adv_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spr_addr_i | input | 16 | Special-register flat address |
| spr_wdata_i | input | 32 | Store data |
| spr_we_i | input | 1 | Store strobe |
| spr_rdata_o | output | 32 | Read data for the presented address |
| exc_entry_i | input | 1 | Exception entry pulse |
| irq_pending_i | input | 1 | A pending enabled interrupt |
| timer_kick_i | input | 1 | Tick timer was reprogrammed |
| halt_o | output | 1 | Core halt request to the pipeline |
| pc_adv_o | output | 1 | One-cycle strobe: step next PC by 4 |
| slow_factor_o | output | 4 | Slow-down factor field |
| doze_o | output | 1 | Doze request field |
| sleep_o | output | 1 | Sleep request field |
| clk_gate_o | output | 1 | Dynamic clock-gating enable |
| suspend_o | output | 1 | Suspend enable |

## Verification
A corrupted stored word shows up on the field outputs and on the read port at the decoded address. It is visible in the cycle straight after the store or exception that produced it. A wrong halt state shows up on `halt_o` one clock after the triggering store or wake event. A halt that is missed, stuck or released too early is therefore seen within a single cycle. A wrong strobe is either missing in the cycle halt rises or present in a later cycle, and both cases are visible on `pc_adv_o`.

// File: rtl/pm_pkg.sv
package pm_pkg;

    localparam int unsigned SPR_ADDR_W  = 16;
    localparam int unsigned SPR_DATA_W  = 32;
    localparam int unsigned GROUP_SHIFT = 11;

    // Stored word. Packing order gives the bit positions:
    // suspend=7, clk_gate=6, sleep=5, doze=4, slow=3:0.
    typedef struct packed {
        logic       suspend;
        logic       clk_gate;
        logic       sleep;
        logic       doze;
        logic [3:0] slow;
    } pm_fields_t;

    localparam int unsigned FIELD_W = $bits(pm_fields_t);

    function automatic logic [SPR_ADDR_W-1:0] spr_flat_addr(input int unsigned grp,
                                                            input int unsigned num);
        return SPR_ADDR_W'((grp << GROUP_SHIFT) + num);
    endfunction

endpackage

// File: rtl/pm_field_reg.sv
module pm_field_reg
    import pm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_hit,
    input  pm_fields_t wr_val,
    input  logic       exc_entry,
    output pm_fields_t fields_q
);

    typedef struct packed {
        pm_fields_t f;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hit) begin
            st_d.f = wr_val;
        end
        if (exc_entry) begin
            st_d.f.doze  = 1'b0;
            st_d.f.sleep = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fields_q = st_q.f;

    p_exc_clears_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        exc_entry |=> (!fields_q.doze && !fields_q.sleep));

    p_exc_keeps_rest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_entry && !wr_hit) |=> (fields_q.slow == $past(fields_q.slow)
                                    && fields_q.suspend == $past(fields_q.suspend)));

    p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_entry && !wr_hit) |=> $stable(fields_q));

endmodule

// File: rtl/pm_halt_ctrl.sv
module pm_halt_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic enter_req,
    input  logic exc_entry,
    input  logic irq_pending,
    input  logic timer_kick,
    output logic halt_q_o,
    output logic adv_q_o
);

    typedef struct packed {
        logic halt;
        logic adv;
    } halt_state_t;

    halt_state_t st_d, st_q;
    logic        wake;
    logic        enter_ok;

    assign wake     = exc_entry | irq_pending | timer_kick;
    assign enter_ok = enter_req & ~exc_entry;

    always_comb begin
        st_d     = st_q;
        st_d.adv = 1'b0;
        if (st_q.halt) begin
            st_d.halt = ~wake;
        end else if (enter_ok) begin
            st_d.halt = 1'b1;
            st_d.adv  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign halt_q_o = st_q.halt;
    assign adv_q_o  = st_q.adv;

    p_enter_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_req && !exc_entry && !halt_q_o) |=> (halt_q_o && adv_q_o));

    p_adv_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adv_q_o |=> !adv_q_o);

    p_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_q_o && wake) |=> !halt_q_o);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_q_o && !wake) |=> (halt_q_o && !adv_q_o));

    p_stay_awake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_q_o && !enter_req) |=> !halt_q_o);

endmodule

// File: rtl/pm_idle_ctrl.sv
module pm_idle_ctrl
    import pm_pkg::*;
#(
    parameter int unsigned ADDR_W  = SPR_ADDR_W,
    parameter int unsigned DATA_W  = SPR_DATA_W,
    parameter int unsigned PM_GRP  = 8,
    parameter int unsigned PM_NUM  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] spr_addr_i,
    input  logic [DATA_W-1:0] spr_wdata_i,
    input  logic              spr_we_i,
    output logic [DATA_W-1:0] spr_rdata_o,
    input  logic              exc_entry_i,
    input  logic              irq_pending_i,
    input  logic              timer_kick_i,
    output logic              halt_o,
    output logic              pc_adv_o,
    output logic [3:0]        slow_factor_o,
    output logic              doze_o,
    output logic              sleep_o,
    output logic              clk_gate_o,
    output logic              suspend_o
);

    localparam logic [ADDR_W-1:0] PM_ADDR = ADDR_W'(spr_flat_addr(PM_GRP, PM_NUM));
    localparam int unsigned       PAD_W   = DATA_W - FIELD_W;

    logic       addr_hit;
    logic       wr_hit;
    logic       enter_req;
    pm_fields_t wr_val;
    pm_fields_t fields;
    logic       unused_wdata_hi;

    assign addr_hit        = (spr_addr_i == PM_ADDR);
    assign wr_hit          = addr_hit & spr_we_i;
    assign wr_val          = pm_fields_t'(spr_wdata_i[FIELD_W-1:0]);
    assign enter_req       = wr_hit & (wr_val.doze | wr_val.sleep);
    assign unused_wdata_hi = ^spr_wdata_i[DATA_W-1:FIELD_W];

    pm_field_reg u_fields (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (wr_hit),
        .wr_val    (wr_val),
        .exc_entry (exc_entry_i),
        .fields_q  (fields)
    );

    pm_halt_ctrl u_halt (
        .clk         (clk),
        .rst_n       (rst_n),
        .enter_req   (enter_req),
        .exc_entry   (exc_entry_i),
        .irq_pending (irq_pending_i),
        .timer_kick  (timer_kick_i),
        .halt_q_o    (halt_o),
        .adv_q_o     (pc_adv_o)
    );

    always_comb begin
        spr_rdata_o = '0;
        if (addr_hit) begin
            spr_rdata_o = {{PAD_W{1'b0}}, fields};
        end
    end

    assign slow_factor_o = fields.slow;
    assign doze_o        = fields.doze;
    assign sleep_o       = fields.sleep;
    assign clk_gate_o    = fields.clk_gate;
    assign suspend_o     = fields.suspend;

    p_miss_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_we_i && !addr_hit && !exc_entry_i) |=> $stable(fields));

    p_store_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !exc_entry_i) |=> (fields == $past(wr_val)));

    p_read_zero_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_hit |-> (spr_rdata_o == '0));

endmodule

// File: tb/pm_idle_ctrl_tb.sv
module pm_idle_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0, exc = 1'b0, irq = 1'b0, kick = 1'b0;
    logic [31:0] rdata;
    logic        halt, adv, doze, sleep, cgate, susp;
    logic [3:0]  slow;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    pm_idle_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .spr_addr_i(addr), .spr_wdata_i(wdata),
        .spr_we_i(we), .spr_rdata_o(rdata), .exc_entry_i(exc),
        .irq_pending_i(irq), .timer_kick_i(kick), .halt_o(halt),
        .pc_adv_o(adv), .slow_factor_o(slow), .doze_o(doze),
        .sleep_o(sleep), .clk_gate_o(cgate), .suspend_o(susp)
    );

    typedef struct packed {
        logic [15:0] a;
        logic [31:0] d;
        logic        w, e, i, k;
        logic        x_halt, x_adv;
        logic [31:0] x_rd;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{16'h4000, 32'h0000_00C3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_00C3}, // R7
        '{16'h4000, 32'hFFFF_FF0A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_000A}, // R2 high bits dropped
        '{16'h4001, 32'h0000_0030, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000}, // R1 miss
        '{16'h4000, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_000A}, // R5 R1
        '{16'h4000, 32'h0000_001A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_001A}, // R3 doze
        '{16'h4000, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_001A}, // R9
        '{16'h4000, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_001A}, // R6 irq
        '{16'h4000, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_001A}, // R6 stays low
        '{16'h4000, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_000A}, // R4 clear
        '{16'h4000, 32'h0000_0025, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_0025}, // R3 sleep
        '{16'h4000, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0025}, // R6 kick
        '{16'h4000, 32'h0000_0030, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000}, // R4 same-cycle
        '{16'h4000, 32'h0000_0060, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_0060}, // R3
        '{16'h4000, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0040}  // R6 R4 exc wake
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] a, input logic [31:0] d,
                         input logic w, input logic e, input logic i, input logic k);
        @(negedge clk);
        addr = a; wdata = d; we = w; exc = e; irq = i; kick = k;
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got hung expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R8 reset state
        check("R8 halt", {31'b0, halt}, 32'h0);
        check("R8 adv", {31'b0, adv}, 32'h0);
        addr = 16'h4000;
        #1;
        check("R8 word", rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int n = 0; n < NV; n++) begin
            drive(VECS[n].a, VECS[n].d, VECS[n].w, VECS[n].e, VECS[n].i, VECS[n].k);
            check($sformatf("vector %0d halt", n), {31'b0, halt}, {31'b0, VECS[n].x_halt});
            check($sformatf("vector %0d adv", n), {31'b0, adv}, {31'b0, VECS[n].x_adv});
            check($sformatf("vector %0d rdata", n), rdata, VECS[n].x_rd);
        end

        // R2 field decode on 0xC9: slow 9, doze 0, sleep 0, gating 1, suspend 1
        drive(16'h4000, 32'h0000_00C9, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R2 slow", {28'b0, slow}, 32'h9);
        check("R2 doze/sleep/gate/susp", {28'b0, susp, cgate, sleep, doze}, 32'hC);
        // R2 sleep and doze bits both set reach their outputs (and halt, R3)
        drive(16'h4000, 32'h0000_0031, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R2 doze+sleep", {30'b0, sleep, doze}, 32'h3);
        check("R3 halt", {31'b0, halt}, 32'h1);
        drive(16'h4000, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R3 adv one cycle", {31'b0, adv}, 32'h0);
        check("R9 still halted", {31'b0, halt}, 32'h1);

        // R8 reset during halt
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        check("R8 halt after reset", {31'b0, halt}, 32'h0);
        check("R8 word after reset", rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: store to another group leaves the word unchanged
        drive(16'h0000, 32'h0000_0010, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R1 no halt", {31'b0, halt}, 32'h0);
        drive(16'h4000, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R1 word kept", rdata, 32'h0);

        finish_run();
    end

endmodule